// File: doc/BRIEF.md
# Prescaled Instruction Timer/Counter

This block is the 8-bit timer/counter of a small microcontroller core. In timer mode it counts retired instructions. Each retired instruction that is not suppressed advances a 5-bit prescaler. The count goes up by one each time the prescaler rolls over, so the count moves once every 32 counted instructions. In event mode the count goes up on each falling edge of an external event pin instead. The pin is first passed through a short synchronizer.

When the count rolls from its maximum back to zero, a sticky overflow flag is set. If the timer interrupt is enabled at that moment, an interrupt request is also latched. The core's branch unit tests the flag through `ovf_flag_o` and clears it with the same test strobe. The interrupt unit clears a pending request with an acknowledge.

The control inputs are the start-timer, start-event, stop, interrupt-enable and interrupt-disable commands. An instruction that carries one of these commands is not counted, and neither is an instruction flagged by the skip qualifier. The suppression applies to that one instruction only. The core can load the count from its accumulator and read it back at any time.

Top module: `instr_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, no interrupt is requested, the interrupt is disabled and the block is stopped; retired instructions then leave the count at 0.
- R2: In timer mode each retired instruction that is not suppressed advances the 5-bit prescaler, and the count increments once on every 32nd such instruction (when the prescaler rolls from 31 to 0).
- R3: The start-timer command clears the prescaler and selects timer mode, so the next increment comes after exactly 32 further counted instructions.
- R4: A retired instruction with `skip_i` high, or one that carries any of the five commands (start-timer, start-event, stop, interrupt enable, interrupt disable), does not advance the prescaler; the next retired instruction without these is counted normally.
- R5: When the count rolls from 0xFF to 0x00, `ovf_flag_o` becomes 1 in the next cycle and stays set until tested.
- R6: A rollover while the interrupt is enabled raises `irq_o`, which stays high until acknowledged; a rollover while it is disabled leaves `irq_o` low.
- R7: The interrupt-disable command clears both the enable and any pending request; `irq_o` is low in the cycle after it.
- R8: During a flag test `ovf_flag_o` shows the flag as it was before the test, and the flag is 0 after the test, unless a rollover in the same cycle sets it, which takes priority.
- R9: `load_i` writes `load_val_i` into the count, visible on `count_o` one cycle later; a load overrides an increment in the same cycle, and that increment then neither sets the flag nor raises an interrupt.
- R10: In event mode the count increments once per falling edge of `event_i`, visible SYNC_STAGES+1 cycles after the edge; rising edges and retired instructions do not change it, and a rollover in this mode sets the flag.
- R11: After the stop command, neither retired instructions nor event edges change the count. When stop and start-timer arrive together, stop wins.
- R12: `irq_ack_i` clears a pending interrupt request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| skip_i | input | 1 | Retired instruction must not be counted |
| start_tmr_i | input | 1 | Start-timer command (clears prescaler) |
| start_evt_i | input | 1 | Start-event-counting command |
| stop_i | input | 1 | Stop command |
| irq_en_i | input | 1 | Enable timer interrupt |
| irq_dis_i | input | 1 | Disable timer interrupt and drop pending request |
| irq_ack_i | input | 1 | Interrupt unit accepts the request |
| load_i | input | 1 | Load the count |
| load_val_i | input | 8 | Value to load (accumulator) |
| flag_test_i | input | 1 | Branch test of the flag; clears it |
| event_i | input | 1 | External event pin, counted on falling edges |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Overflow flag as seen by the branch test |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The hardest situation to reach from the ports is the prescaler position itself. It is never visible, so every check on increment timing depends on knowing its phase exactly. The stimulus keeps that phase known. It always re-enters timer mode through start-timer, and every group of counted instructions is a multiple of 32. The suppression and start-clears tests then stop one instruction short of a rollover, insert the instruction under test, and watch whether the next single counted instruction moves the count. The races between a rollover and a load or a flag test use the same approach: the count is loaded with 0xFF so that the rollover lands in the chosen cycle.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_TIMER = 2'd1,
        MODE_EVENT = 2'd2
    } itc_mode_e;

    typedef struct packed {
        itc_mode_e mode;
        logic      flag;
        logic      irq_en;
        logic      irq_pend;
    } itc_ctrl_t;

endpackage

// File: rtl/itc_prescaler.sv
module itc_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [PRE_W-1:0] pre_o,
    output logic             wrap_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        wrap_o = 1'b0;
        if (clear_i) begin
            pre_d = '0;
        end else if (advance_i) begin
            pre_d  = pre_q + 1'b1;
            wrap_o = (pre_q == PRE_MAX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pre_o = pre_q;
endmodule

// File: rtl/itc_event_edge.sv
module itc_event_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = evt_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], evt_i};
        end
    endgenerate

    always_comb begin
        last_d = sync_q[STAGES-1];
        fall_o = last_q & ~sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end
endmodule

// File: rtl/instr_timer.sv
module instr_timer #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             skip_i,
    input  logic             start_tmr_i,
    input  logic             start_evt_i,
    input  logic             stop_i,
    input  logic             irq_en_i,
    input  logic             irq_dis_i,
    input  logic             irq_ack_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             flag_test_i,
    input  logic             event_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    import itc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    itc_ctrl_t        ctrl_d, ctrl_q;
    logic [CNT_W-1:0] count_d, count_q;

    logic             cmd_any;
    logic             suppress;
    logic             pre_adv;
    logic             pre_wrap;
    logic [PRE_W-1:0] pre_q;
    logic             evt_fall;
    logic             cnt_inc;
    logic             rollover;
    itc_mode_e        mode_q;

    assign mode_q = ctrl_q.mode;

    always_comb begin
        cmd_any  = start_tmr_i | start_evt_i | stop_i | irq_en_i | irq_dis_i;
        suppress = skip_i | cmd_any;
        pre_adv  = retire_i & ~suppress & (ctrl_q.mode == MODE_TIMER);
    end

    itc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_tmr_i),
        .advance_i (pre_adv),
        .pre_o     (pre_q),
        .wrap_o    (pre_wrap)
    );

    itc_event_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (event_i),
        .fall_o (evt_fall)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        count_d = count_q;

        cnt_inc  = ((ctrl_q.mode == MODE_TIMER) & pre_wrap)
                 | ((ctrl_q.mode == MODE_EVENT) & evt_fall);
        rollover = cnt_inc & (count_q == CNT_MAX) & ~load_i;

        // count
        if (load_i)       count_d = load_val_i;
        else if (cnt_inc) count_d = count_q + 1'b1;

        // mode: stop over start-timer over start-event
        if (stop_i)           ctrl_d.mode = MODE_IDLE;
        else if (start_tmr_i) ctrl_d.mode = MODE_TIMER;
        else if (start_evt_i) ctrl_d.mode = MODE_EVENT;

        // interrupt enable: disable wins
        if (irq_dis_i)     ctrl_d.irq_en = 1'b0;
        else if (irq_en_i) ctrl_d.irq_en = 1'b1;

        // overflow flag: set beats test-clear
        if (rollover)         ctrl_d.flag = 1'b1;
        else if (flag_test_i) ctrl_d.flag = 1'b0;

        // pending request
        if (rollover & ctrl_q.irq_en & ~irq_dis_i) ctrl_d.irq_pend = 1'b1;
        else if (irq_dis_i | irq_ack_i)             ctrl_d.irq_pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '{mode: MODE_IDLE, flag: 1'b0, irq_en: 1'b0, irq_pend: 1'b0};
            count_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            count_q <= count_d;
        end
    end

    assign count_o    = count_q;
    assign ovf_flag_o = ctrl_q.flag;
    assign irq_o      = ctrl_q.irq_pend;
endmodule

// File: rtl/instr_timer_checker.sv
module instr_timer_checker #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_i,
    input logic             skip_i,
    input logic             start_tmr_i,
    input logic             stop_i,
    input logic             irq_dis_i,
    input logic             irq_ack_i,
    input logic             load_i,
    input logic             flag_test_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_flag_o,
    input logic             irq_o,
    input logic [PRE_W-1:0] pre_q,
    input itc_pkg::itc_mode_e mode_q
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_o) == CMAX && count_o == '0 && !$past(load_i)) |-> ovf_flag_o);

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1)));

    assert_skip_holds_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && skip_i && !start_tmr_i) |=> $stable(pre_q));

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_tmr_i |=> (pre_q == '0));

    assert_dis_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dis_i |=> !irq_o);

    assert_ack_drops_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && count_o != CMAX) |=> !irq_o);

    assert_test_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_test_i && count_o != CMAX) |=> !ovf_flag_o);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == itc_pkg::MODE_IDLE && !load_i) |=> $stable(count_o));

    assert_stop_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (mode_q == itc_pkg::MODE_IDLE));
endmodule

bind instr_timer instr_timer_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .skip_i      (skip_i),
    .start_tmr_i (start_tmr_i),
    .stop_i      (stop_i),
    .irq_dis_i   (irq_dis_i),
    .irq_ack_i   (irq_ack_i),
    .load_i      (load_i),
    .flag_test_i (flag_test_i),
    .count_o     (count_o),
    .ovf_flag_o  (ovf_flag_o),
    .irq_o       (irq_o),
    .pre_q       (pre_q),
    .mode_q      (mode_q)
);

// File: tb/tb_instr_timer.sv
module tb_instr_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retire_i = 0, skip_i = 0, start_tmr_i = 0, start_evt_i = 0, stop_i = 0;
    logic       irq_en_i = 0, irq_dis_i = 0, irq_ack_i = 0, load_i = 0, flag_test_i = 0;
    logic [7:0] load_val_i = 8'h00;
    logic       event_i = 1'b1;
    logic [7:0] count_o;
    logic       ovf_flag_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    instr_timer dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .skip_i(skip_i),
        .start_tmr_i(start_tmr_i), .start_evt_i(start_evt_i), .stop_i(stop_i),
        .irq_en_i(irq_en_i), .irq_dis_i(irq_dis_i), .irq_ack_i(irq_ack_i),
        .load_i(load_i), .load_val_i(load_val_i), .flag_test_i(flag_test_i),
        .event_i(event_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // inputs set at a negedge; one posedge; back at negedge, pulses cleared
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        retire_i = 0; skip_i = 0; start_tmr_i = 0; start_evt_i = 0; stop_i = 0;
        irq_en_i = 0; irq_dis_i = 0; irq_ack_i = 0; load_i = 0; flag_test_i = 0;
    endtask

    task automatic retire_n(input int n);
        for (int i = 0; i < n; i++) begin
            retire_i = 1;
            cyc();
        end
    endtask

    task automatic load(input logic [7:0] v);
        load_i = 1; load_val_i = v;
        cyc();
    endtask

    task automatic t_reset();
        check("R1 count", count_o, 0);
        check("R1 flag", ovf_flag_o, 0);
        check("R1 irq", irq_o, 0);
        retire_n(40);
        check("R1 stopped count", count_o, 0);
    endtask

    task automatic t_timer_rate();
        load(8'h10);
        start_tmr_i = 1; retire_i = 1; cyc();
        retire_n(31);
        check("R2 before 32nd", count_o, 8'h10);
        retire_n(1);
        check("R2 on 32nd", count_o, 8'h11);
    endtask

    task automatic t_start_clears();
        retire_n(10);
        start_tmr_i = 1; retire_i = 1; cyc();
        retire_n(31);
        check("R3 after restart 31", count_o, 8'h11);
        retire_n(1);
        check("R3 after restart 32", count_o, 8'h12);
    endtask

    task automatic t_suppress();
        retire_n(31);
        check("R4 pre-edge", count_o, 8'h12);
        retire_i = 1; skip_i = 1; cyc();
        check("R4 skip", count_o, 8'h12);
        retire_i = 1; irq_dis_i = 1; cyc();
        check("R4 command", count_o, 8'h12);
        retire_n(1);
        check("R4 next counted", count_o, 8'h13);
    endtask

    task automatic t_wrap_noirq();
        load(8'hFF);
        retire_n(32);
        check("R5 wrap count", count_o, 0);
        check("R5 flag set", ovf_flag_o, 1);
        check("R6 no irq when disabled", irq_o, 0);
        flag_test_i = 1;
        check("R8 test sees flag", ovf_flag_o, 1);
        cyc();
        check("R8 flag cleared", ovf_flag_o, 0);
    endtask

    task automatic t_wrap_irq();
        irq_en_i = 1; cyc();
        load(8'hFF);
        retire_n(32);
        check("R6 irq raised", irq_o, 1);
        cyc(); cyc(); cyc();
        check("R6 irq held", irq_o, 1);
        irq_ack_i = 1; cyc();
        check("R12 ack clears", irq_o, 0);
        load(8'hFF);
        retire_n(32);
        check("R6 irq again", irq_o, 1);
        irq_dis_i = 1; cyc();
        check("R7 disable clears pending", irq_o, 0);
        load(8'hFF);
        retire_n(32);
        check("R7 no irq after disable", irq_o, 0);
        check("R5 flag still set", ovf_flag_o, 1);
        flag_test_i = 1; cyc();
    endtask

    task automatic t_load_override();
        load(8'hFF);
        retire_n(31);
        retire_i = 1; load_i = 1; load_val_i = 8'h40; cyc();
        check("R9 load wins", count_o, 8'h40);
        check("R9 no flag", ovf_flag_o, 0);
    endtask

    task automatic t_flag_race();
        load(8'hFF);
        retire_n(31);
        retire_i = 1; flag_test_i = 1;
        check("R8 test sees clear flag", ovf_flag_o, 0);
        cyc();
        check("R8 set beats clear", ovf_flag_o, 1);
        flag_test_i = 1; cyc();
        check("R8 cleared after", ovf_flag_o, 0);
    endtask

    task automatic t_event();
        stop_i = 1; cyc();
        start_evt_i = 1; cyc();
        load(8'h05);
        retire_n(40);
        check("R10 retires ignored", count_o, 8'h05);
        event_i = 0;
        cyc(); cyc();
        check("R10 not before sync", count_o, 8'h05);
        cyc();
        check("R10 falling edge", count_o, 8'h06);
        event_i = 1;
        for (int i = 0; i < 5; i++) cyc();
        check("R10 rising ignored", count_o, 8'h06);
        event_i = 0;
        for (int i = 0; i < 5; i++) cyc();
        check("R10 second fall", count_o, 8'h07);
        event_i = 1;
        for (int i = 0; i < 5; i++) cyc();
        load(8'hFF);
        event_i = 0;
        for (int i = 0; i < 5; i++) cyc();
        check("R10 wrap count", count_o, 0);
        check("R10 wrap flag", ovf_flag_o, 1);
        event_i = 1;
        for (int i = 0; i < 5; i++) cyc();
    endtask

    task automatic t_stop();
        load(8'h22);
        stop_i = 1; cyc();
        event_i = 0;
        for (int i = 0; i < 5; i++) cyc();
        event_i = 1;
        retire_n(40);
        check("R11 stopped", count_o, 8'h22);
        stop_i = 1; start_tmr_i = 1; cyc();
        retire_n(40);
        check("R11 stop beats start", count_o, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_timer_rate();
        t_start_clears();
        t_suppress();
        t_wrap_noirq();
        t_wrap_irq();
        t_load_override();
        t_flag_race();
        t_event();
        t_stop();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule